// File: doc/BRIEF.md
# Scan-Testable Four-State Control Machine

This block is a small control sequencer with four states (idle, running, finished, fault) whose two state flip-flops are built as mux-D scan cells joined into one serial chain. In normal operation it advances on the handshake inputs `start`, `fin`, `ack` and `clr`, and raises `busy` while it is running.

For manufacturing test, `scan_en` turns the state register into a two-bit shift register between `scan_in` and `scan_out`. A tester shifts any state in, drops `scan_en` for one capture clock so the next-state logic makes exactly one transition, then shifts the result out and compares it. While `scan_mode` is high the reset input is masked, so a stray reset cannot overwrite a state that has been shifted in. The reset is synchronous.

Top module: `scan_ctl_fsm`

## Requirements
- R1: With `scan_mode` low and `rst_n` low at a rising clock edge, the state becomes IDLE (code 0) and `busy` goes low. State codes are IDLE=0, RUN=1, DONE=2, ERR=3.
- R2: From IDLE, a capture clock with `start` high moves to RUN; with `start` low the state stays IDLE.
- R3: From RUN, a capture clock with `fin` high moves to DONE regardless of `clr`; with `fin` low and `clr` high it moves to ERR; with both low it stays RUN.
- R4: From DONE, a capture clock with `ack` high moves to IDLE; otherwise the state stays DONE.
- R5: From ERR, a capture clock with `clr` high moves to IDLE; otherwise the state stays ERR.
- R6: `busy` is high exactly when the state code is 1 (RUN).
- R7: With `scan_en` high, each rising edge loads `scan_in` into state bit 0 and the old bit 0 into bit 1; `scan_out` always shows state bit 1, so a state is loaded by shifting bit 1 first, then bit 0.
- R8: While `scan_mode` is high, `rst_n` has no effect: shifting and capture behave as if reset were deasserted.
- R9: With `scan_en` low, each rising edge loads the functional next state whether `scan_mode` is high or low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset, masked in test mode |
| scan_mode | input | 1 | Test mode; forces the reset inactive |
| scan_en | input | 1 | High: shift the chain; low: functional capture |
| scan_in | input | 1 | Serial chain input, enters state bit 0 |
| start | input | 1 | Begin request, taken in IDLE |
| fin | input | 1 | Completion indication, taken in RUN |
| ack | input | 1 | Acknowledge, taken in DONE |
| clr | input | 1 | Abort in RUN, recovery in ERR |
| busy | output | 1 | High while in RUN |
| scan_out | output | 1 | Serial chain output, state bit 1 |

## Verification
The assertions assume every input is known and steady around each rising edge, and that `scan_mode` does not change inside a load, capture and unload sequence; the transition properties only hold for clocks where the effective reset is inactive. The bench changes inputs only on falling edges, holds `scan_mode` high across whole shift/capture/shift sequences, and sweeps every state code against all sixteen combinations of the handshake inputs, plus a functional walk with `scan_mode` low and a masked-reset capture.

// File: rtl/scan_ctl_fsm.sv
module scan_ctl_fsm #(
  parameter int SW = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scan_mode,
  input  logic scan_en,
  input  logic scan_in,
  input  logic start,
  input  logic fin,
  input  logic ack,
  input  logic clr,
  output logic busy,
  output logic scan_out
);
  localparam logic [SW-1:0] S_IDLE = SW'(0);
  localparam logic [SW-1:0] S_RUN  = SW'(1);
  localparam logic [SW-1:0] S_DONE = SW'(2);
  localparam logic [SW-1:0] S_ERR  = SW'(3);

  logic [SW-1:0] state, nxt, shifted;
  logic          rst_act_n;

  assign rst_act_n = rst_n | scan_mode;
  assign shifted   = {state[SW-2:0], scan_in};

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE: if (start) nxt = S_RUN;
      S_RUN:  if (fin) nxt = S_DONE; else if (clr) nxt = S_ERR;
      S_DONE: if (ack) nxt = S_IDLE;
      S_ERR:  if (clr) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_act_n)   state <= S_IDLE;
    else if (scan_en) state <= shifted;
    else              state <= nxt;
  end

  assign busy     = (state == S_RUN);
  assign scan_out = state[SW-1];
endmodule

// File: rtl/scan_ctl_fsm_chk.sv
module scan_ctl_fsm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scan_mode,
  input logic       scan_en,
  input logic       scan_in,
  input logic       start,
  input logic       fin,
  input logic       ack,
  input logic       clr,
  input logic       busy,
  input logic       scan_out,
  input logic [1:0] state
);
  logic started = 1'b0;
  logic in_rst;
  always_ff @(posedge clk) started <= 1'b1;
  assign in_rst = !rst_n && !scan_mode;

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!started)
    in_rst |=> (state == 2'd0 && !busy));
  p_start_run_r2: assert property (@(posedge clk) disable iff (!started || in_rst)
    (!scan_en && state == 2'd0 && start) |=> busy);
  p_fin_done_r3: assert property (@(posedge clk) disable iff (!started || in_rst)
    (!scan_en && state == 2'd1 && fin) |=> (state == 2'd2));
  p_ack_idle_r4: assert property (@(posedge clk) disable iff (!started || in_rst)
    (!scan_en && state == 2'd2 && ack) |=> (state == 2'd0));
  p_clr_idle_r5: assert property (@(posedge clk) disable iff (!started || in_rst)
    (!scan_en && state == 2'd3 && clr) |=> (state == 2'd0));
  p_shift_r7: assert property (@(posedge clk) disable iff (!started || in_rst)
    scan_en |=> (scan_out == $past(state[0]) && state[0] == $past(scan_in)));
  p_masked_reset_r8: assert property (@(posedge clk) disable iff (!started)
    (scan_mode && !rst_n && scan_en) |=> (state[0] == $past(scan_in)));
  p_test_capture_r9: assert property (@(posedge clk) disable iff (!started)
    (scan_mode && !scan_en && state == 2'd2 && !ack) |=> (state == 2'd2));
endmodule

bind scan_ctl_fsm scan_ctl_fsm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scan_mode(scan_mode), .scan_en(scan_en),
  .scan_in(scan_in), .start(start), .fin(fin), .ack(ack), .clr(clr),
  .busy(busy), .scan_out(scan_out), .state(state)
);

// File: tb/scan_ctl_fsm_bench.sv
module scan_ctl_fsm_bench;
  logic clk = 1'b0;
  logic rst_n, scan_mode, scan_en, scan_in, start, fin, ack, clr;
  logic busy, scan_out;
  int   n_run = 0, n_fail = 0;
  bit   done = 0;

  always #4 clk = ~clk;

  scan_ctl_fsm u_scan_ctl_fsm (
    .clk(clk), .rst_n(rst_n), .scan_mode(scan_mode), .scan_en(scan_en),
    .scan_in(scan_in), .start(start), .fin(fin), .ack(ack), .clr(clr),
    .busy(busy), .scan_out(scan_out)
  );

  function automatic logic [1:0] model(logic [1:0] s, logic st, logic fi, logic ak, logic cl);
    case (s)
      2'd0: return st ? 2'd1 : 2'd0;
      2'd1: return fi ? 2'd2 : (cl ? 2'd3 : 2'd1);
      2'd2: return ak ? 2'd0 : 2'd2;
      default: return cl ? 2'd0 : 2'd3;
    endcase
  endfunction

  task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load(logic [1:0] s);
    scan_en = 1; scan_in = s[1]; step();
    scan_in = s[0]; step();
    scan_en = 0;
  endtask

  task automatic unload(string req, logic [1:0] exp);
    chk(req, {1'b0, scan_out}, {1'b0, exp[1]});
    scan_en = 1; scan_in = 0; step();
    chk(req, {1'b0, scan_out}, {1'b0, exp[0]});
    scan_en = 0;
  endtask

  function automatic string req_of(logic [1:0] s);
    case (s)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    rst_n = 0; scan_mode = 0; scan_en = 0; scan_in = 0;
    start = 0; fin = 0; ack = 0; clr = 0;
    @(negedge clk); step();
    chk("R1 reset busy", {1'b0, busy}, 2'd0);
    chk("R1 reset scan_out", {1'b0, scan_out}, 2'd0);
    rst_n = 1;

    start = 1; step(); start = 0;
    chk("R6 busy in RUN", {1'b0, busy}, 2'd1);
    fin = 1; clr = 1; step(); fin = 0; clr = 0;
    chk("R3 RUN fin over clr", {1'b0, busy}, 2'd0);
    chk("R3 DONE code bit1", {1'b0, scan_out}, 2'd1);
    ack = 1; step(); ack = 0;
    chk("R4 back to IDLE", {1'b0, scan_out}, 2'd0);
    start = 1; step(); start = 0;
    clr = 1; step(); clr = 0;
    chk("R3 RUN clr to ERR bit1", {1'b0, scan_out}, 2'd1);
    chk("R6 busy low in ERR", {1'b0, busy}, 2'd0);
    clr = 1; step(); clr = 0;
    chk("R5 ERR clr to IDLE", {1'b0, scan_out}, 2'd0);
    start = 1; step(); start = 0;
    rst_n = 0; step(); rst_n = 1;
    chk("R1 reset from RUN", {1'b0, busy}, 2'd0);

    scan_mode = 1;
    for (int s = 0; s < 4; s++) begin
      for (int v = 0; v < 16; v++) begin
        load(2'(s));
        chk("R7 load scan_out", {1'b0, scan_out}, {1'b0, s[1]});
        chk("R6 busy after load", {1'b0, busy}, {1'b0, s == 1});
        {start, fin, ack, clr} = 4'(v);
        step();
        start = 0; fin = 0; ack = 0; clr = 0;
        unload(req_of(2'(s)), model(2'(s), v[3], v[2], v[1], v[0]));
      end
    end

    rst_n = 0;
    load(2'd2);
    chk("R8 load ignores reset", {1'b0, scan_out}, 2'd1);
    step();
    unload("R8 capture ignores reset", 2'd2);
    load(2'd3);
    clr = 1; step(); clr = 0;
    unload("R9 test-mode capture", 2'd0);
    scan_mode = 0; step();
    rst_n = 1;
    chk("R1 reset after test mode", {1'b0, scan_out}, 2'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule